// File: doc/BRIEF.md
# Fractional-Duty Baud Clock Divider

This block derives a baud-rate clock from a fast system clock. Three slow level signals can serve as its input clock: an on-chip reference level and two external pin levels. The pin levels are resynchronised to the system clock before use. Both edges of the chosen level count as input events. An optional divide-by-16 prescaler follows the source select. A 12-bit down-counter then divides the result. It is preset from a divisor field, reloads at zero and toggles the output level on each expiry. Because every input half-period is an event, odd divide ratios still give an exact 50% duty cycle. Successive toggles fall alternately on a falling and a rising input edge.

A single 32-bit control word holds all settings: a soft reset, a run enable, the source code, the divisor and the prescale selector. It is numbered here with bit 0 as the least significant bit. Alongside the level clock, the block drives a one-cycle pulse on every output toggle. Downstream logic can use that pulse as a clock enable, and a bench can use it to measure period and duty cycle.

Top module: `baudgen`

## Requirements
- R1: With the prescaler off, `baud_clk` toggles once every CD+1 edges (rising or falling) of the selected source, where CD is `ctrl_word[12:1]`. CD=0 toggles on every edge and CD=4095 toggles every 4096 edges.
- R2: Consecutive toggle intervals of `baud_clk` are equal for both odd and even CD+1, so the high and low phases have the same length.
- R3: When `ctrl_word[0]` is 1, the interval between toggles is 16 times the interval with `ctrl_word[0]` at 0.
- R4: `ctrl_word[15:14]` selects the input: 2'b00 selects `ref_lvl`, 2'b01 selects `pin_a` and 2'b10 selects `pin_b`.
- R5: With `ctrl_word[15:14]` = 2'b11, no input events occur, `baud_clk` holds its level and `baud_tick` stays low.
- R6: While `ctrl_word[17]` is 1, `baud_clk` is 1 and `baud_tick` is 0 from the next clock edge onward. When the bit is cleared, the count restarts from the full divisor.
- R7: While `rst_n` is low at a clock edge, `baud_clk` becomes 1 and `baud_tick` becomes 0.
- R8: While `ctrl_word[16]` is 0 (and `ctrl_word[17]` is 0), the counter and `baud_clk` hold and no `baud_tick` occurs. Counting resumes when the bit returns to 1.
- R9: A new CD value is loaded only at the next reload. The interval in progress keeps the old length and the following one uses the new value.
- R10: `baud_tick` is high for exactly the one cycle in which `baud_clk` shows its new level after a toggle, and at no other time.
- R11: Bits `ctrl_word[31:18]` and the autobaud bit `ctrl_word[13]` have no effect on `baud_clk` or `baud_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge |
| ctrl_word | input | 32 | Control word: soft reset [17], enable [16], source [15:14], autobaud [13] (unused), divisor [12:1], prescale [0] |
| ref_lvl | input | 1 | On-chip reference level, already synchronous to `clk` |
| pin_a | input | 1 | External clock level A, asynchronous |
| pin_b | input | 1 | External clock level B, asynchronous |
| baud_clk | output | 1 | Divided baud clock level, high in reset |
| baud_tick | output | 1 | One-cycle pulse on every `baud_clk` toggle |

## Verification
The assertions assume that the source code in `ctrl_word` is changed only while the soft reset bit is set or while the code is 2'b11. A swap between two live sources can present a level step as an input edge. The stimulus therefore writes every new source and prescale setting under the soft reset bit and measures only after the first toggle that follows. The assertions also assume that source levels toggle no faster than every two system cycles. The bench generators toggle every 2, 3 and 5 cycles, so each edge survives the synchroniser as a separate event.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

   // Control word layout, bit 0 = least significant bit
   localparam int CTRL_W     = 32;
   localparam int B_PRE16    = 0;
   localparam int B_DIV_LO   = 1;
   localparam int B_DIV_HI   = 12;
   localparam int B_AUTOBAUD = 13;
   localparam int B_SRC_LO   = 14;
   localparam int B_SRC_HI   = 15;
   localparam int B_RUN      = 16;
   localparam int B_SOFTRST  = 17;
   localparam int DIV_FIELD_W = B_DIV_HI - B_DIV_LO + 1;
   localparam int N_SRC       = 3;

   typedef enum logic [1:0] {
      SRC_REF   = 2'b00,
      SRC_PIN_A = 2'b01,
      SRC_PIN_B = 2'b10,
      SRC_NONE  = 2'b11
   } src_sel_e;

   typedef struct packed {
      logic                   soft_rst;
      logic                   run;
      src_sel_e               src;
      logic [DIV_FIELD_W-1:0] div;
      logic                   pre16;
   } bg_cfg_t;

endpackage

// File: rtl/baudgen_sync.sv
module baudgen_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         for (genvar i = 0; i < STAGES; i++) begin : g_st
            logic s;
            if (i == 0) begin : g_first
               always_ff @(posedge clk) begin
                  if (!rst_n) s <= 1'b0;
                  else        s <= d;
               end
            end else begin : g_next
               always_ff @(posedge clk) begin
                  if (!rst_n) s <= 1'b0;
                  else        s <= g_st[i-1].s;
               end
            end
         end
         assign q = g_st[STAGES-1].s;
      end
   endgenerate

endmodule

// File: rtl/baudgen_srcsel.sv
module baudgen_srcsel
   import baudgen_pkg::*;
#(
   parameter int PIN_SYNC_STAGES = 2,
   parameter int REF_SYNC_STAGES = 0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ref_lvl,
   input  logic     pin_a,
   input  logic     pin_b,
   input  src_sel_e sel,
   output logic     edge_evt
);

   logic [N_SRC-1:0] raw_lvl;
   logic [N_SRC-1:0] syn_lvl;
   logic             cur_lvl;
   logic             last_lvl;

   assign raw_lvl = {pin_b, pin_a, ref_lvl};

   generate
      for (genvar k = 0; k < N_SRC; k++) begin : g_src
         localparam int DEPTH = (k == 0) ? REF_SYNC_STAGES : PIN_SYNC_STAGES;
         baudgen_sync #(.STAGES(DEPTH)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_lvl[k]),
            .q    (syn_lvl[k])
         );
      end
   endgenerate

   always_comb begin
      case (sel)
         SRC_REF:   cur_lvl = syn_lvl[0];
         SRC_PIN_A: cur_lvl = syn_lvl[1];
         SRC_PIN_B: cur_lvl = syn_lvl[2];
         default:   cur_lvl = last_lvl;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_lvl <= 1'b0;
      else        last_lvl <= cur_lvl;
   end

   assign edge_evt = (sel != SRC_NONE) && (cur_lvl != last_lvl);

endmodule

// File: rtl/baudgen_prescale.sv
module baudgen_prescale #(
   parameter int PRE_DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic pre_on,
   input  logic evt_in,
   output logic evt_out
);

   generate
      if (PRE_DIV == 1) begin : g_bypass
         logic unused_pre;
         assign unused_pre = ^{clk, rst_n, clr, pre_on};
         assign evt_out    = evt_in;
      end else begin : g_count
         localparam int PW = $clog2(PRE_DIV);
         logic [PW-1:0] pcnt;

         always_ff @(posedge clk) begin
            if (!rst_n || clr)         pcnt <= '0;
            else if (evt_in && pre_on) pcnt <= pcnt + 1'b1;
         end

         assign evt_out = pre_on ? (evt_in && (pcnt == {PW{1'b1}})) : evt_in;
      end
   endgenerate

endmodule

// File: rtl/baudgen_divider.sv
module baudgen_divider #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             evt,
   input  logic [DIV_W-1:0] div,
   output logic             out_lvl,
   output logic             out_tick
);

   logic [DIV_W-1:0] cnt;
   logic             expire;

   assign expire = evt && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt      <= div;
         out_lvl  <= 1'b1;
         out_tick <= 1'b0;
      end else begin
         out_tick <= expire;
         if (expire) begin
            cnt     <= div;
            out_lvl <= ~out_lvl;
         end else if (evt) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/baudgen.sv
module baudgen
   import baudgen_pkg::*;
#(
   parameter int DIV_W           = 12,
   parameter int PRE_DIV         = 16,
   parameter int PIN_SYNC_STAGES = 2,
   parameter int REF_SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic              ref_lvl,
   input  logic              pin_a,
   input  logic              pin_b,
   output logic              baud_clk,
   output logic              baud_tick
);

   generate
      if (DIV_W < 1 || DIV_W > DIV_FIELD_W) begin : g_bad_div
         $error("baudgen: DIV_W must lie in 1..%0d", DIV_FIELD_W);
      end
      if (PRE_DIV < 1 || (PRE_DIV & (PRE_DIV - 1)) != 0) begin : g_bad_pre
         $error("baudgen: PRE_DIV must be a power of two");
      end
      if (PIN_SYNC_STAGES < 2) begin : g_bad_sync
         $error("baudgen: PIN_SYNC_STAGES must be at least 2");
      end
      if (REF_SYNC_STAGES < 0) begin : g_bad_ref
         $error("baudgen: REF_SYNC_STAGES must not be negative");
      end
   endgenerate

   bg_cfg_t cfg;
   logic    edge_evt;
   logic    live_evt;
   logic    div_evt;
   logic    unused_bits;

   assign cfg.soft_rst = ctrl_word[B_SOFTRST];
   assign cfg.run      = ctrl_word[B_RUN];
   assign cfg.src      = src_sel_e'(ctrl_word[B_SRC_HI:B_SRC_LO]);
   assign cfg.div      = ctrl_word[B_DIV_HI:B_DIV_LO];
   assign cfg.pre16    = ctrl_word[B_PRE16];

   assign unused_bits = ^{ctrl_word[CTRL_W-1:B_SOFTRST+1], ctrl_word[B_AUTOBAUD], cfg.div};

   baudgen_srcsel #(
      .PIN_SYNC_STAGES(PIN_SYNC_STAGES),
      .REF_SYNC_STAGES(REF_SYNC_STAGES)
   ) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_lvl (ref_lvl),
      .pin_a   (pin_a),
      .pin_b   (pin_b),
      .sel     (cfg.src),
      .edge_evt(edge_evt)
   );

   assign live_evt = edge_evt && cfg.run && !cfg.soft_rst;

   baudgen_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cfg.soft_rst),
      .pre_on (cfg.pre16),
      .evt_in (live_evt),
      .evt_out(div_evt)
   );

   baudgen_divider #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cfg.soft_rst),
      .evt     (div_evt),
      .div     (cfg.div[DIV_W-1:0]),
      .out_lvl (baud_clk),
      .out_tick(baud_tick)
   );

endmodule

// File: rtl/baudgen_chk.sv
module baudgen_chk
   import baudgen_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [CTRL_W-1:0] ctrl_word,
   input logic              baud_clk,
   input logic              baud_tick
);

   AST_SOFT_RST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_word[B_SOFTRST] |=> (baud_clk && !baud_tick)); // R6

   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_word[B_RUN] && !ctrl_word[B_SOFTRST]) |=> ($stable(baud_clk) && !baud_tick)); // R8

   AST_NO_SOURCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_word[B_SRC_HI:B_SRC_LO] == 2'b11) && !ctrl_word[B_SOFTRST]) |=> ($stable(baud_clk) && !baud_tick)); // R5

   AST_TICK_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> (baud_clk != $past(baud_clk))); // R10

   AST_CHANGE_HAS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ctrl_word[B_SOFTRST]) && (baud_clk != $past(baud_clk))) |-> baud_tick); // R10

endmodule

bind baudgen baudgen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl_word(ctrl_word),
   .baud_clk (baud_clk),
   .baud_tick(baud_tick)
);

// File: tb/sim_baudgen.sv
module sim_baudgen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ctrl = 32'h0;
   logic        ref_lvl = 1'b0;
   logic        pin_a = 1'b0;
   logic        pin_b = 1'b0;
   logic        baud_clk;
   logic        baud_tick;

   localparam int HP_REF = 2;
   localparam int HP_A   = 3;
   localparam int HP_B   = 5;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   baudgen u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_word(ctrl),
      .ref_lvl  (ref_lvl),
      .pin_a    (pin_a),
      .pin_b    (pin_b),
      .baud_clk (baud_clk),
      .baud_tick(baud_tick)
   );

   initial forever begin repeat (HP_REF) @(posedge clk); #1 ref_lvl = ~ref_lvl; end
   initial forever begin repeat (HP_A)   @(posedge clk); #1 pin_a   = ~pin_a;   end
   initial forever begin repeat (HP_B)   @(posedge clk); #1 pin_b   = ~pin_b;   end

   function automatic logic [31:0] mk(input bit srst, input bit run, input logic [1:0] src,
                                      input int cd, input bit p16);
      logic [31:0] w;
      w        = 32'h0;
      w[17]    = srst;
      w[16]    = run;
      w[15:14] = src;
      w[12:1]  = cd[11:0];
      w[0]     = p16;
      return w;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_tick(input int limit, output int n, output bit got);
      n   = 0;
      got = 1'b0;
      while (n < limit) begin
         @(negedge clk);
         n++;
         if (baud_tick) begin
            got = 1'b1;
            break;
         end
      end
   endtask

   // apply a configuration under soft reset, then check nint steady toggle intervals
   task automatic measure(input logic [1:0] src, input int cd, input bit p16, input int hp,
                          input int nint, input logic [31:0] extra, input string req);
      int  exp;
      int  n;
      bit  got;
      logic prev;
      exp = (cd + 1) * hp * (p16 ? 16 : 1);
      @(negedge clk);
      ctrl = mk(1'b1, 1'b1, src, cd, p16) | extra;
      repeat (2) @(negedge clk);
      ctrl = mk(1'b0, 1'b1, src, cd, p16) | extra;
      wait_tick(exp * 3 + 40, n, got);
      check(got, req, "first toggle seen", longint'(got), 1);
      prev = baud_clk;
      for (int k = 0; k < nint; k++) begin
         wait_tick(exp + 40, n, got);
         check(got && n == exp, req, $sformatf("interval cd=%0d pre16=%0d src=%0d", cd, p16, src),
               n, exp);
         check(baud_clk != prev, "R2", "level alternates after toggle", baud_clk, !prev);
         prev = baud_clk;
      end
   endtask

   initial begin
      int   n;
      bit   got;
      int   ticks;
      bit   held;
      logic lvl;

      // R7: hard reset state
      ctrl = mk(1'b0, 1'b1, 2'b00, 3, 1'b0);
      repeat (4) @(negedge clk);
      check(baud_clk == 1'b1, "R7", "baud_clk in reset", baud_clk, 1);
      check(baud_tick == 1'b0, "R7", "baud_tick in reset", baud_tick, 0);
      rst_n = 1'b1;

      // R1/R2: exhaustive small divisors on the reference, odd and even ratios
      for (int cd = 0; cd < 16; cd++) measure(2'b00, cd, 1'b0, HP_REF, 2, 32'h0, "R1");
      // R1: largest divisor
      measure(2'b00, 4095, 1'b0, HP_REF, 1, 32'h0, "R1");

      // R3: prescaler on
      for (int cd = 0; cd < 5; cd++) measure(2'b00, cd, 1'b1, HP_REF, 2, 32'h0, "R3");

      // R4: external sources
      measure(2'b01, 2, 1'b0, HP_A, 3, 32'h0, "R4");
      measure(2'b10, 5, 1'b0, HP_B, 3, 32'h0, "R4");
      measure(2'b01, 1, 1'b1, HP_A, 2, 32'h0, "R4");

      // R11: reserved bits and autobaud bit set
      measure(2'b00, 6, 1'b0, HP_REF, 3, 32'hFFFC_2000, "R11");
      measure(2'b10, 2, 1'b1, HP_B, 2, 32'hFFFC_2000, "R11");

      // R9: divisor change applies at next reload
      measure(2'b00, 9, 1'b0, HP_REF, 1, 32'h0, "R9");
      ctrl = mk(1'b0, 1'b1, 2'b00, 3, 1'b0);
      wait_tick(100, n, got);
      check(got && n == 20, "R9", "interval after change keeps old divisor", n, 20);
      wait_tick(100, n, got);
      check(got && n == 8, "R9", "following interval uses new divisor", n, 8);

      // R5: no-source code
      measure(2'b00, 4, 1'b0, HP_REF, 1, 32'h0, "R5");
      ctrl  = mk(1'b0, 1'b1, 2'b11, 4, 1'b0);
      lvl   = baud_clk;
      ticks = 0;
      held  = 1'b1;
      repeat (300) begin
         @(negedge clk);
         if (baud_tick) ticks++;
         if (baud_clk != lvl) held = 1'b0;
      end
      check(ticks == 0, "R5", "ticks with source 11", ticks, 0);
      check(held, "R5", "baud_clk held with source 11", held, 1);

      // R8: enable gating
      measure(2'b00, 4, 1'b0, HP_REF, 1, 32'h0, "R8");
      ctrl  = mk(1'b0, 1'b0, 2'b00, 4, 1'b0);
      lvl   = baud_clk;
      ticks = 0;
      held  = 1'b1;
      repeat (200) begin
         @(negedge clk);
         if (baud_tick) ticks++;
         if (baud_clk != lvl) held = 1'b0;
      end
      check(ticks == 0, "R8", "ticks while disabled", ticks, 0);
      check(held, "R8", "baud_clk held while disabled", held, 1);
      ctrl = mk(1'b0, 1'b1, 2'b00, 4, 1'b0);
      wait_tick(40, n, got);
      check(got, "R8", "toggle resumes after enable", longint'(got), 1);
      wait_tick(40, n, got);
      check(got && n == 10, "R8", "interval after resume", n, 10);

      // R6: soft reset forces high while low
      measure(2'b00, 7, 1'b0, HP_REF, 1, 32'h0, "R6");
      if (baud_clk) wait_tick(40, n, got);
      check(baud_clk == 1'b0, "R6", "level low before soft reset", baud_clk, 0);
      ctrl  = mk(1'b1, 1'b1, 2'b00, 7, 1'b0);
      ticks = 0;
      held  = 1'b1;
      repeat (100) begin
         @(negedge clk);
         if (baud_tick) ticks++;
         if (baud_clk != 1'b1) held = 1'b0;
      end
      check(held, "R6", "baud_clk high during soft reset", held, 1);
      check(ticks == 0, "R6", "ticks during soft reset", ticks, 0);
      measure(2'b00, 7, 1'b0, HP_REF, 2, 32'h0, "R6");

      // R7: hard reset mid-run while low
      if (baud_clk) wait_tick(40, n, got);
      rst_n = 1'b0;
      @(negedge clk);
      check(baud_clk == 1'b1, "R7", "baud_clk after mid-run reset", baud_clk, 1);
      check(baud_tick == 1'b0, "R7", "baud_tick after mid-run reset", baud_tick, 0);
      rst_n = 1'b1;
      measure(2'b00, 3, 1'b0, HP_REF, 2, 32'h0, "R7");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", 190000, 0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule